// File: doc/BRIEF.md
# Overlay Logo Cancellation Pixel Datapath

This block removes a semi-transparent logo that a broadcaster has blended into a video picture. For every pixel it takes the live colour samples and two template values fetched from frame memory for the same location: a gain term and an offset term. Each colour channel is scaled by the gain, with a gain of 128 meaning exactly one. The offset is then subtracted, and the result is limited to the legal 8-bit range. Where the gain is above unity the pixel lies inside the logo, and a flag is raised so that a later spatial filter can act on that region.

The datapath is a fixed three-stage pipeline clocked by the pixel clock and accepts one pixel on every cycle. A per-pixel bypass input sends the live video through unchanged with the same latency, so the modes can be switched without a timing slip. The flag travels through the same number of stages as the video, so it stays aligned with its own pixel.

Top module: `logo_cancel_dp`

## Requirements
- R1: While rst_n is low, vid_out and logo_zone are all zero.
- R2: The inputs presented in one cycle (vid_in, tmpl_gain, tmpl_ofs, bypass) produce their result on vid_out and logo_zone after the third rising clock edge. A new pixel is accepted on every cycle, and each result depends only on its own inputs.
- R3: With tmpl_gain = 128 and tmpl_ofs = 0, each channel of vid_out equals the matching channel of vid_in.
- R4: In process mode (bypass = 0) each channel is out = floor(in × gain / 128) − ofs, computed without loss and then limited to 0..255. The gain and the offset are shared by the three channels. Red is vid_in[23:16], green is [15:8] and blue is [7:0], and vid_out uses the same layout.
- R5: A channel whose unclamped result exceeds 255 reads 255. It does not wrap modulo 256.
- R6: A channel whose unclamped result is below 0 reads 0.
- R7: The offset only darkens. For the same input and gain, a nonzero offset never gives a higher channel value than an offset of 0.
- R8: With bypass = 1, vid_out equals vid_in for any gain and offset, with the same three-cycle latency as process mode.
- R9: logo_zone is 1 exactly when the pixel's tmpl_gain is greater than 128, in either mode, and it is aligned with that pixel on vid_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel (dot) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | 1: pass live video through; 0: apply the correction |
| vid_in | input | 24 | Live pixel, red [23:16], green [15:8], blue [7:0] |
| tmpl_gain | input | 8 | Template gain for this pixel, 128 = unity |
| tmpl_ofs | input | 8 | Template offset for this pixel, subtracted after the gain |
| vid_out | output | 24 | Corrected pixel, same channel layout as vid_in |
| logo_zone | output | 1 | Pixel lies inside the logo (gain above unity) |

## Verification
The bench targets both clamp edges. A bright pixel with a gain near the maximum must read 255; a design that wraps would show the complementary dark value, such as 56 instead of 255. An offset larger than the scaled value must read 0; a design that wraps would show a value near white. Unity gain is checked at 0, 1, 127 and 255. The gain is swept across 127, 128 and 129, which catches an off-by-one in the logo-zone compare or in the shift. Back-to-back streams that alternate between bypass and process with extreme templates expose a bypass path with the wrong latency, a flag that lags or leads its pixel, and a gain or offset that leaks into a neighbouring pixel.

// File: rtl/lc_pkg.sv
package lc_pkg;

   // Two ways of building the saturating subtract after the gain shift.
   typedef enum logic {
      CLAMP_BIASED = 1'b0,   // lift by a constant, compare unsigned, remove constant
      CLAMP_SIGNED = 1'b1    // plain two's-complement difference and sign test
   } clamp_style_e;

   localparam int LC_PIX_W_DEF = 8;
   localparam int LC_NUM_CH_DEF = 3;

endpackage

// File: rtl/lc_lane.sv
module lc_lane #(
   parameter int                   PIX_W = 8,
   parameter lc_pkg::clamp_style_e CLAMP = lc_pkg::CLAMP_BIASED
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byp,
   input  logic [PIX_W-1:0] pix,
   input  logic [PIX_W-1:0] gain,
   input  logic [PIX_W-1:0] ofs,
   output logic [PIX_W-1:0] pix_out
);

   localparam int PROD_W = 2 * PIX_W;
   localparam int ACC_W  = 2 * PIX_W + 1;
   localparam int FRAC   = PIX_W - 1;
   localparam logic [ACC_W-1:0] MAXV = ACC_W'({PIX_W{1'b1}});
   localparam logic [ACC_W-1:0] BIAS = ACC_W'(1) << PIX_W;
   localparam logic [ACC_W-1:0] TOPV = BIAS + MAXV;

   // stage 2: full-precision product and the terms that travel with it
   logic [PROD_W-1:0] prod_q;
   logic [PIX_W-1:0]  ofs_q;
   logic [PIX_W-1:0]  pix_q;
   logic              byp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q <= '0;
         ofs_q  <= '0;
         pix_q  <= '0;
         byp_q  <= 1'b0;
      end else begin
         prod_q <= PROD_W'(pix) * PROD_W'(gain);
         ofs_q  <= ofs;
         pix_q  <= pix;
         byp_q  <= byp;
      end
   end

   logic [ACC_W-1:0] shf;
   logic [PIX_W-1:0] lim;

   assign shf = ACC_W'(prod_q >> FRAC);

   generate
      if (CLAMP == lc_pkg::CLAMP_BIASED) begin : g_biased
         logic [ACC_W-1:0] lifted;
         always_comb begin
            lifted = shf + BIAS - ACC_W'(ofs_q);
            if (lifted < BIAS)
               lim = '0;
            else if (lifted > TOPV)
               lim = '1;
            else
               lim = PIX_W'(lifted - BIAS);
         end
      end else begin : g_signed
         logic signed [ACC_W-1:0] diff;
         always_comb begin
            diff = $signed(shf) - $signed(ACC_W'(ofs_q));
            if (diff < 0)
               lim = '0;
            else if (diff > $signed(MAXV))
               lim = '1;
            else
               lim = PIX_W'(diff);
         end
      end
   endgenerate

   // stage 3: output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pix_out <= '0;
      else
         pix_out <= byp_q ? pix_q : lim;
   end

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp_q && (shf >= ACC_W'(ofs_q) + MAXV)) |=> (pix_out == {PIX_W{1'b1}}));

   assert_floor_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp_q && (shf <= ACC_W'(ofs_q))) |=> (pix_out == '0));

   assert_only_darkens_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !byp_q |=> (ACC_W'(pix_out) <= $past(shf)));

   assert_bypass_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byp_q |=> (pix_out == $past(pix_q)));

endmodule

// File: rtl/lc_zone_flag.sv
module lc_zone_flag #(
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] gain,
   output logic             zone
);

   localparam logic [PIX_W-1:0] UNITY = PIX_W'(1) << (PIX_W - 1);

   logic zone_s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zone_s2 <= 1'b0;
         zone    <= 1'b0;
      end else begin
         zone_s2 <= (gain > UNITY);
         zone    <= zone_s2;
      end
   end

   assert_zone_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      zone_s2 |=> zone);

endmodule

// File: rtl/logo_cancel_dp.sv
module logo_cancel_dp #(
   parameter int                   PIX_W       = lc_pkg::LC_PIX_W_DEF,
   parameter int                   NUM_CH      = lc_pkg::LC_NUM_CH_DEF,
   parameter lc_pkg::clamp_style_e CLAMP_STYLE = lc_pkg::CLAMP_BIASED
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bypass,
   input  logic [NUM_CH*PIX_W-1:0] vid_in,
   input  logic [PIX_W-1:0]        tmpl_gain,
   input  logic [PIX_W-1:0]        tmpl_ofs,
   output logic [NUM_CH*PIX_W-1:0] vid_out,
   output logic                    logo_zone
);

   localparam int BUS_W = NUM_CH * PIX_W;
   localparam logic [PIX_W-1:0] UNITY = PIX_W'(1) << (PIX_W - 1);

   if (PIX_W < 2) begin : g_bad_width
      $error("logo_cancel_dp: PIX_W must be at least 2");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("logo_cancel_dp: NUM_CH must be at least 1");
   end

   // stage 1: entry registers
   logic [BUS_W-1:0] vid_s1;
   logic [PIX_W-1:0] gain_s1;
   logic [PIX_W-1:0] ofs_s1;
   logic             byp_s1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vid_s1  <= '0;
         gain_s1 <= '0;
         ofs_s1  <= '0;
         byp_s1  <= 1'b0;
      end else begin
         vid_s1  <= vid_in;
         gain_s1 <= tmpl_gain;
         ofs_s1  <= tmpl_ofs;
         byp_s1  <= bypass;
      end
   end

   // stages 2 and 3: one arithmetic lane per colour channel
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
      lc_lane #(
         .PIX_W (PIX_W),
         .CLAMP (CLAMP_STYLE)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .byp     (byp_s1),
         .pix     (vid_s1[ch*PIX_W +: PIX_W]),
         .gain    (gain_s1),
         .ofs     (ofs_s1),
         .pix_out (vid_out[ch*PIX_W +: PIX_W])
      );
   end

   lc_zone_flag #(
      .PIX_W (PIX_W)
   ) u_zone (
      .clk   (clk),
      .rst_n (rst_n),
      .gain  (gain_s1),
      .zone  (logo_zone)
   );

   // cycles since reset release, saturating; gates the end-to-end checks
   logic [1:0] fill_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fill_q <= '0;
      else if (fill_q != 2'd3)
         fill_q <= fill_q + 2'd1;
   end

   assert_zone_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q == 2'd3) |-> (logo_zone == ($past(tmpl_gain, 3) > UNITY)));

   assert_bypass_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((fill_q == 2'd3) && $past(bypass, 3)) |-> (vid_out == $past(vid_in, 3)));

   assert_unity_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((fill_q == 2'd3) && ($past(tmpl_gain, 3) == UNITY) && ($past(tmpl_ofs, 3) == '0))
      |-> (vid_out == $past(vid_in, 3)));

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |-> (vid_out == '0 && !logo_zone));

endmodule

// File: tb/sim_logo_cancel_dp.sv
module sim_logo_cancel_dp;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bypass = 1'b0;
   logic [23:0] vid_in = '0;
   logic [7:0]  tmpl_gain = '0;
   logic [7:0]  tmpl_ofs = '0;
   logic [23:0] vid_out;
   logic        logo_zone;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   typedef struct {
      int          stamp;
      logic [23:0] pix;
      logic        zone;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) cyc <= cyc + 1;

   logo_cancel_dp u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bypass    (bypass),
      .vid_in    (vid_in),
      .tmpl_gain (tmpl_gain),
      .tmpl_ofs  (tmpl_ofs),
      .vid_out   (vid_out),
      .logo_zone (logo_zone)
   );

   function automatic logic [7:0] model_ch(input int px, input int g, input int o);
      int v;
      v = ((px * g) >> 7) - o;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      return 8'(v);
   endfunction

   // driver: present one pixel at a falling edge and queue its expected result
   task automatic drive_px(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                           input int m, input int c, input logic byp, input string tag);
      exp_t e;
      @(negedge clk);
      vid_in    = {r, g, b};
      tmpl_gain = 8'(m);
      tmpl_ofs  = 8'(c);
      bypass    = byp;
      e.stamp = cyc;
      e.tag   = tag;
      e.zone  = (m > 128);
      if (byp)
         e.pix = {r, g, b};
      else
         e.pix = {model_ch(r, m, c), model_ch(g, m, c), model_ch(b, m, c)};
      sb.push_back(e);
   endtask

   // monitor: compare three clock edges after each pixel was presented
   always @(negedge clk) begin
      if (rst_n && sb.size() > 0 && (cyc - sb[0].stamp) >= 3) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (vid_out !== e.pix || logo_zone !== e.zone) begin
            errors++;
            $display("FAIL %s: vid_out=%h zone=%b expected vid_out=%h zone=%b",
                     e.tag, vid_out, logo_zone, e.pix, e.zone);
         end
      end
   end

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: outputs clear while reset is held, even with busy inputs
      vid_in = 24'hFFFFFF; tmpl_gain = 8'd200; tmpl_ofs = 8'd0;
      repeat (3) @(negedge clk);
      checks++;
      if (vid_out !== 24'h0 || logo_zone !== 1'b0) begin
         errors++;
         $display("FAIL R1: vid_out=%h zone=%b expected vid_out=000000 zone=0", vid_out, logo_zone);
      end
      rst_n = 1'b1;

      // R3: unity gain, zero offset
      drive_px(8'd0,   8'd1,   8'd127, 128, 0, 1'b0, "R3_unity_a");
      drive_px(8'd255, 8'd200, 8'd64,  128, 0, 1'b0, "R3_unity_b");

      // R4: general correction, shared template across channels
      drive_px(8'd200, 8'd77,  8'd10,  64,  10, 1'b0, "R4_half_gain");
      drive_px(8'd77,  8'd150, 8'd33,  100, 3,  1'b0, "R4_mid_gain");
      drive_px(8'd90,  8'd180, 8'd240, 160, 20, 1'b0, "R4_logo_gain");

      // R5: saturate high, no wrap
      drive_px(8'd255, 8'd200, 8'd130, 255, 0, 1'b0, "R5_sat_high_a");
      drive_px(8'd200, 8'd255, 8'd129, 200, 0, 1'b0, "R5_sat_high_b");

      // R6: saturate low
      drive_px(8'd20,  8'd49,  8'd50,  128, 50, 1'b0, "R6_sat_low_a");
      drive_px(8'd255, 8'd0,   8'd9,   0,   1,  1'b0, "R6_sat_low_b");

      // R7: same input and gain, offset 0 then 30
      drive_px(8'd120, 8'd60,  8'd25,  140, 0,  1'b0, "R7_ofs_zero");
      drive_px(8'd120, 8'd60,  8'd25,  140, 30, 1'b0, "R7_ofs_thirty");

      // R8: bypass ignores extreme templates, interleaved with processing
      drive_px(8'd17,  8'd250, 8'd3,   255, 255, 1'b1, "R8_bypass_a");
      drive_px(8'd17,  8'd250, 8'd3,   255, 255, 1'b0, "R8_process_b");
      drive_px(8'd200, 8'd100, 8'd50,  0,   200, 1'b1, "R8_bypass_c");

      // R9: compare boundary around unity, in both modes
      drive_px(8'd80, 8'd80, 8'd80, 127, 0, 1'b0, "R9_gain127");
      drive_px(8'd80, 8'd80, 8'd80, 128, 0, 1'b0, "R9_gain128");
      drive_px(8'd80, 8'd80, 8'd80, 129, 0, 1'b0, "R9_gain129");
      drive_px(8'd80, 8'd80, 8'd80, 129, 0, 1'b1, "R9_gain129_bypass");

      // R2: dense stream, every pixel different from its neighbours
      for (int i = 0; i < 40; i++) begin
         drive_px(8'((i * 37) & 255), 8'((i * 91 + 5) & 255), 8'((255 - i * 13) & 255),
                  (i * 29 + 100) & 255, (i * 11) & 63, 1'(i % 3 == 0), "R2_stream");
      end

      while (sb.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule